// File: doc/BRIEF.md
# Boost Output Voltage Supervisor

This block supervises the regulated output of a boost converter from a sampled feedback code. An ADC gives one unsigned code per clock, scaled so that `NOM_CODE` is the regulation point. All thresholds are parameters in per-mille of that point. The block produces four outputs:

- A power-good pull-down request for an external open-drain stage.
- A hysteretic over-voltage flag that holds off the gate drive.
- A low-feedback fault that stops switching and resets soft start.
- A combined gate-inhibit output.

Power good is released only after the feedback has stayed inside the regulation window for `DELAY_TICKS` consecutive clocks. It is withdrawn on the next clock edge when either of two conditions holds:

- the feedback falls to a programmable stop level, or
- the feedback rises above a hard over-voltage level.

Between the over-voltage set point and that hard level, switching is held off, but power good is not touched. While the reference-good input is low, every output sits in its fault state. This covers undervoltage lockout and shutdown.

Each threshold code is floor(`NOM_CODE` * per-mille / 1000). With the defaults (`NOM_CODE`=512) the codes are:

| Threshold | Per-mille | Code |
|---|---|---|
| Window low | 960 | 491 |
| Window high / over-voltage clear | 1055 | 540 |
| Over-voltage set | 1075 | 550 |
| Power-good over-voltage | 1200 | 614 |
| Low fault | 200 | 102 |
| Stop-level ceiling | 920 | 471 |

Top module: `boost_out_supervisor`

## Requirements
- R1: While rst_ni is low, and on the clock edge after ref_good_i is sampled low, pg_pull_o, ov_flag_o, fb_low_o and gate_inhibit_o are all 1.
- R2: With pg_pull_o at 1 and no drop condition, pg_pull_o becomes 0 on the edge of the DELAY_TICKS-th consecutive sample inside the window. The window is window low ≤ code ≤ window high, both ends inclusive.
- R3: If a sample leaves the window before the terminal count, the count restarts from zero. A full DELAY_TICKS run of in-window samples is then needed again.
- R4: A sample at or below the stop level sets pg_pull_o to 1 on the next edge, with no delay.
- R5: The stop level is stop_code_i. A value of 0 selects the low-fault code. Any value above the ceiling code is clamped to the ceiling.
- R6: ov_flag_o sets on the edge after a sample above the set code. It clears on the edge after a sample at or below the window-high code. Samples in between leave it unchanged.
- R7: While power good is released, samples above the stop level and at or below the power-good over-voltage code keep pg_pull_o at 0. This holds both below the window and inside the over-voltage band.
- R8: A sample above the power-good over-voltage code sets pg_pull_o to 1 on the next edge. Release then needs a complete new in-window delay.
- R9: fb_low_o is 1 on the edge after a sample below the low-fault code, and 0 after any other sample while ref_good_i is high.
- R10: gate_inhibit_o is the OR of ov_flag_o and fb_low_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_good_i | input | 1 | Reference good; low forces every output to its fault state |
| fb_code_i | input | ADC_W | Sampled feedback code |
| stop_code_i | input | ADC_W | Power-good stop level; 0 selects the default |
| pg_pull_o | output | 1 | 1 = hold power-good line low (not good) |
| ov_flag_o | output | 1 | Hysteretic over-voltage flag |
| fb_low_o | output | 1 | Low-feedback fault; stops switching and resets soft start |
| gate_inhibit_o | output | 1 | Gate drive hold-off |

## Verification
All outputs are registered. Every result is therefore due exactly one clock after the sample that causes it, except the power-good release, which is due DELAY_TICKS clocks after the first in-window sample. The bench changes fb_code_i on a falling edge and reads the outputs on the next falling edge, after the single rising edge that consumed the sample. For each delay check, it counts falling edges from the first in-window sample. It checks the release one edge before the terminal count and again at the terminal count. The full-range sweeps of over-voltage set, over-voltage clear, low fault and power-good drop follow the same one-step rule.

// File: rtl/boost_sup_pkg.sv
package boost_sup_pkg;
  function automatic int unsigned pm_code(int unsigned nom, int unsigned pm);
    return (nom * pm) / 1000;
  endfunction
endpackage

// File: rtl/boost_sup_levels.sv
module boost_sup_levels
  import boost_sup_pkg::*;
#(
  parameter int unsigned ADC_W     = 10,
  parameter int unsigned NOM_CODE  = 512,
  parameter int unsigned WIN_LO_PM = 960,
  parameter int unsigned WIN_HI_PM = 1055,
  parameter int unsigned OV_SET_PM = 1075,
  parameter int unsigned PG_OV_PM  = 1200,
  parameter int unsigned LOW_PM    = 200,
  parameter int unsigned STOP_MAX_PM = 920
) (
  input  logic [ADC_W-1:0] fb_code_i,
  input  logic [ADC_W-1:0] stop_code_i,
  output logic             in_win_o,
  output logic             ov_set_o,
  output logic             ov_clr_o,
  output logic             pg_ov_o,
  output logic             at_stop_o,
  output logic             below_low_o
);
  localparam logic [ADC_W-1:0] WIN_LO   = ADC_W'(pm_code(NOM_CODE, WIN_LO_PM));
  localparam logic [ADC_W-1:0] WIN_HI   = ADC_W'(pm_code(NOM_CODE, WIN_HI_PM));
  localparam logic [ADC_W-1:0] OV_SET   = ADC_W'(pm_code(NOM_CODE, OV_SET_PM));
  localparam logic [ADC_W-1:0] PG_OV    = ADC_W'(pm_code(NOM_CODE, PG_OV_PM));
  localparam logic [ADC_W-1:0] LOW      = ADC_W'(pm_code(NOM_CODE, LOW_PM));
  localparam logic [ADC_W-1:0] STOP_MAX = ADC_W'(pm_code(NOM_CODE, STOP_MAX_PM));

  logic [ADC_W-1:0] stop_lvl;

  always_comb begin
    if (stop_code_i == '0)          stop_lvl = LOW;
    else if (stop_code_i > STOP_MAX) stop_lvl = STOP_MAX;
    else                             stop_lvl = stop_code_i;
  end

  assign in_win_o    = (fb_code_i >= WIN_LO) && (fb_code_i <= WIN_HI);
  assign ov_set_o    = fb_code_i > OV_SET;
  assign ov_clr_o    = fb_code_i <= WIN_HI;
  assign pg_ov_o     = fb_code_i > PG_OV;
  assign at_stop_o   = fb_code_i <= stop_lvl;
  assign below_low_o = fb_code_i < LOW;
endmodule

// File: rtl/boost_sup_ov.sv
module boost_sup_ov (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_good_i,
  input  logic set_i,
  input  logic clr_i,
  output logic ov_o
);
  logic ov_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ov_q <= 1'b1;
    else if (!ref_good_i) ov_q <= 1'b1;
    else if (set_i)      ov_q <= 1'b1;
    else if (clr_i)      ov_q <= 1'b0;
  end

  assign ov_o = ov_q;

  // R6
  ov_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ov_q);
  // R6
  ov_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_good_i && clr_i) |=> !ov_q);
  // R6
  ov_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_good_i && !set_i && !clr_i) |=> (ov_q == $past(ov_q)));
endmodule

// File: rtl/boost_sup_pg_timer.sv
module boost_sup_pg_timer #(
  parameter int unsigned DELAY_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_good_i,
  input  logic in_win_i,
  input  logic drop_i,
  output logic pg_ok_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pg_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pg_ok_q <= 1'b0;
    end else if (!ref_good_i || drop_i) begin
      cnt_q   <= '0;
      pg_ok_q <= 1'b0;
    end else if (pg_ok_q) begin
      cnt_q <= '0;
    end else if (in_win_i) begin
      if (cnt_q == LAST) begin
        pg_ok_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign pg_ok_o = pg_ok_q;

  // R2
  pg_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_ok_q) |-> $past(in_win_i));
  // R3
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_win_i && !pg_ok_q) |=> (cnt_q == '0));
  // R4
  pg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !pg_ok_q);
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/boost_out_supervisor.sv
module boost_out_supervisor #(
  parameter int unsigned ADC_W       = 10,
  parameter int unsigned NOM_CODE    = 512,
  parameter int unsigned WIN_LO_PM   = 960,
  parameter int unsigned WIN_HI_PM   = 1055,
  parameter int unsigned OV_SET_PM   = 1075,
  parameter int unsigned PG_OV_PM    = 1200,
  parameter int unsigned LOW_PM      = 200,
  parameter int unsigned STOP_MAX_PM = 920,
  parameter int unsigned DELAY_TICKS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_good_i,
  input  logic [ADC_W-1:0] fb_code_i,
  input  logic [ADC_W-1:0] stop_code_i,
  output logic             pg_pull_o,
  output logic             ov_flag_o,
  output logic             fb_low_o,
  output logic             gate_inhibit_o
);
  logic in_win, ov_set, ov_clr, pg_ov, at_stop, below_low;
  logic pg_ok, low_q;

  boost_sup_levels #(
    .ADC_W(ADC_W), .NOM_CODE(NOM_CODE), .WIN_LO_PM(WIN_LO_PM),
    .WIN_HI_PM(WIN_HI_PM), .OV_SET_PM(OV_SET_PM), .PG_OV_PM(PG_OV_PM),
    .LOW_PM(LOW_PM), .STOP_MAX_PM(STOP_MAX_PM)
  ) i_levels (
    .fb_code_i  (fb_code_i),
    .stop_code_i(stop_code_i),
    .in_win_o   (in_win),
    .ov_set_o   (ov_set),
    .ov_clr_o   (ov_clr),
    .pg_ov_o    (pg_ov),
    .at_stop_o  (at_stop),
    .below_low_o(below_low)
  );

  boost_sup_ov i_ov (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_good_i(ref_good_i),
    .set_i     (ov_set),
    .clr_i     (ov_clr),
    .ov_o      (ov_flag_o)
  );

  boost_sup_pg_timer #(.DELAY_TICKS(DELAY_TICKS)) i_pg_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_good_i(ref_good_i),
    .in_win_i  (in_win),
    .drop_i    (at_stop || pg_ov),
    .pg_ok_o   (pg_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_q <= 1'b1;
    else if (!ref_good_i) low_q <= 1'b1;
    else                  low_q <= below_low;
  end

  assign pg_pull_o      = ~pg_ok;
  assign fb_low_o       = low_q;
  assign gate_inhibit_o = ov_flag_o | low_q;

  // R1
  ref_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_good_i |=> (pg_pull_o && ov_flag_o && fb_low_o && gate_inhibit_o));
  // R9
  low_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_good_i && below_low) |=> fb_low_o);
  // R9
  low_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_good_i && !below_low) |=> !fb_low_o);
  // R8
  pg_ov_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_ov |=> pg_pull_o);
endmodule

// File: tb/test_boost_out_supervisor.sv
`timescale 1ns/1ps
module test_boost_out_supervisor;
  localparam int W = 10;
  localparam int NOM = 512;
  localparam int D = 6;
  localparam int WLO = NOM * 960 / 1000;
  localparam int WHI = NOM * 1055 / 1000;
  localparam int OVS = NOM * 1075 / 1000;
  localparam int PGO = NOM * 1200 / 1000;
  localparam int LOWC = NOM * 200 / 1000;
  localparam int SMAX = NOM * 920 / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_good = 1'b0;
  logic [W-1:0] fb = '0;
  logic [W-1:0] stop = '0;
  logic pg_pull, ov_flag, fb_low, gate_inh;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  boost_out_supervisor #(.ADC_W(W), .NOM_CODE(NOM), .DELAY_TICKS(D)) i_boost_out_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .ref_good_i(ref_good), .fb_code_i(fb),
    .stop_code_i(stop), .pg_pull_o(pg_pull), .ov_flag_o(ov_flag),
    .fb_low_o(fb_low), .gate_inhibit_o(gate_inh));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d fb=%0d", req, act, exp, fb);
    end
  endtask

  task automatic step(input int code);
    fb = W'(code);
    @(negedge clk);
  endtask

  task automatic release_pg();
    for (int i = 0; i <= D; i++) step(NOM);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk({pg_pull, ov_flag, fb_low, gate_inh} == 4'hF, "R1 reset", {pg_pull, ov_flag, fb_low, gate_inh}, 15);
    rst_n = 1'b1;
    step(NOM);
    chk(pg_pull && ov_flag && fb_low, "R1 ref low", {pg_pull, ov_flag, fb_low}, 7);
    ref_good = 1'b1;

    // R2 exact delay
    for (int i = 1; i < D; i++) step(NOM);
    chk(pg_pull == 1'b1, "R2 before terminal", pg_pull, 1);
    step(NOM);
    chk(pg_pull == 1'b0, "R2 at terminal", pg_pull, 0);
    chk(ov_flag == 1'b0 && fb_low == 1'b0 && gate_inh == 1'b0, "R10 idle", gate_inh, 0);

    // R1 ref_good drop mid-run
    ref_good = 1'b0;
    step(NOM);
    chk({pg_pull, ov_flag, fb_low, gate_inh} == 4'hF, "R1 ref drop", {pg_pull, ov_flag, fb_low, gate_inh}, 15);
    ref_good = 1'b1;

    // R3 window edges inclusive and restart
    for (int i = 1; i < D; i++) step((i % 2) ? WLO : WHI);
    step(400);
    chk(pg_pull == 1'b1, "R3 excursion", pg_pull, 1);
    for (int i = 1; i < D; i++) step(WLO);
    chk(pg_pull == 1'b1, "R3 restarted", pg_pull, 1);
    step(WHI);
    chk(pg_pull == 1'b0, "R3 full run", pg_pull, 0);

    // R7 below window and in OV band keep release
    step(WLO - 1);
    step(LOWC + 1);
    chk(pg_pull == 1'b0, "R7 below window", pg_pull, 0);
    step(PGO);
    chk(pg_pull == 1'b0 && ov_flag == 1'b1 && gate_inh == 1'b1, "R7 ov band", pg_pull, 0);

    // R8 hard OV, then full new delay
    step(PGO + 1);
    chk(pg_pull == 1'b1, "R8 drop", pg_pull, 1);
    for (int i = 0; i < 3 * D; i++) step(WHI + 20);
    chk(pg_pull == 1'b1 && ov_flag == 1'b1, "R8 above window", pg_pull, 1);
    for (int i = 1; i < D; i++) step(NOM);
    chk(pg_pull == 1'b1 && ov_flag == 1'b0, "R8 partial", pg_pull, 1);
    step(NOM);
    chk(pg_pull == 1'b0, "R8 re-release", pg_pull, 0);

    // R5 programmed and clamped stop level
    stop = 10'd300;
    step(301);
    chk(pg_pull == 1'b0, "R5 above prog", pg_pull, 0);
    step(300);
    chk(pg_pull == 1'b1, "R5 at prog", pg_pull, 1);
    stop = 10'd1000;
    release_pg();
    step(SMAX + 1);
    chk(pg_pull == 1'b0, "R5 above clamp", pg_pull, 0);
    step(SMAX);
    chk(pg_pull == 1'b1, "R5 at clamp", pg_pull, 1);
    stop = '0;

    // R6 and R9 full sweep, from cleared and from set state
    for (int c = 0; c < (1 << W); c++) begin
      step(NOM);
      step(c);
      chk(ov_flag == (c > OVS), "R6 set sweep", ov_flag, int'(c > OVS));
      chk(fb_low == (c < LOWC), "R9 low sweep", fb_low, int'(c < LOWC));
      chk(gate_inh == ((c > OVS) || (c < LOWC)), "R10 sweep", gate_inh, int'((c > OVS) || (c < LOWC)));
      step(PGO);
      step(c);
      chk(ov_flag == (c > WHI), "R6 clear sweep", ov_flag, int'(c > WHI));
    end

    // R4 and R8 drop sweep with default stop level
    for (int c = 0; c < (1 << W); c++) begin
      release_pg();
      step(c);
      chk(pg_pull == ((c <= LOWC) || (c > PGO)), "R4 drop sweep", pg_pull, int'((c <= LOWC) || (c > PGO)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule